// File: doc/BRIEF.md
# Split-Mode Precision Gamma Palette

This block is the colour-correction palette of one display pipe. It holds a 1024-entry table of three 10-bit colours. A host loads the table through an entry-pointer register and a data register. In split operation the table works as two curves laid end to end: the lower 512 entries linearise the incoming pixel (degamma), and the upper 512 entries re-encode the result (gamma). Each pixel channel passes through both curves, one after the other. A 10-bit channel value selects a pair of neighbouring entries, and its lowest bit chooses between the lower entry and the midpoint of the pair.

Each pixel channel also carries an overrange flag that marks a value at or above 1.0. In split operation such a channel takes its output from a per-channel 16-bit ceiling register. A separate 256-entry, 8-bit-per-colour table serves the legacy palette mode. It is written at its own host addresses and never touches the entry pointer.

Pixels are accepted on every cycle. Each result appears three cycles after its input, and the operating mode is sampled with the pixel.

Top module: `gamma_palette`

## Requirements
- R1: After reset, `out_valid` is 0, the mode is legacy, and all three ceiling registers hold 0xFFFF, so a split-mode overrange channel returns 1023.
- R2: Host word offsets on `host_addr[3:0]` (with `host_addr[8]`=0) are: 0 pointer, 1 data, 4/5/6 red/green/blue ceiling, 8 mode. A write to offset 1 stores red from bits 29:20, green from 19:10 and blue from 9:0 into the entry the pointer selects.
- R3: A pointer write loads the entry number from bits 9:0 and the step flag from bit 15. With the step flag set, each data write advances the pointer by one, and the pointer wraps from 1023 to 0. With the flag clear, the pointer holds and repeated data writes overwrite the same entry.
- R4: Mode bit 0 = 1 selects split operation. Input bits 9:1 address degamma entry n. The 10-bit degamma result d then addresses gamma entry 512 + d[9:1].
- R5: In each curve an odd input (bit 0 = 1) yields floor((e[n] + e[n+1]) / 2), and an even input yields e[n]. At the top entry of a curve (n = 511) the neighbour is that same entry.
- R6: In split operation, a channel with its overrange bit (bit 10) set outputs bits 15:6 of that channel's ceiling register. The other channels of the same pixel are unaffected.
- R7: Mode bit 0 = 0 selects legacy operation. A write with `host_addr[8]`=1 stores entry `host_addr[7:0]` with red in bits 23:16, green in 15:8 and blue in 7:0. A channel looks up entry in[9:2], or entry 255 when overrange. The 8-bit entry v is output as {v, v[7:6]}.
- R8: Legacy table writes neither use nor change the entry pointer or its step flag. This holds even when the pointer is non-zero and stepping is enabled.
- R9: A data write and a pixel read of the same entry in the same cycle return the entry's old value. The new value is seen by the next pixel.
- R10: Every accepted pixel produces `out_valid` exactly three clock cycles later. Back-to-back pixels produce back-to-back results in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 9 | Bit 8 selects the legacy table; otherwise the register word offset is in bits 3:0 |
| host_wdata | input | 32 | Host write data |
| pix_valid | input | 1 | Pixel input valid |
| pix_r | input | 11 | Red channel; bit 10 marks overrange |
| pix_g | input | 11 | Green channel; bit 10 marks overrange |
| pix_b | input | 11 | Blue channel; bit 10 marks overrange |
| out_valid | output | 1 | Corrected pixel valid |
| out_r | output | 10 | Corrected red |
| out_g | output | 10 | Corrected green |
| out_b | output | 10 | Corrected blue |

## Verification
The bench builds the block with its default parameters: 10-bit channels, 8-bit legacy entries and 16-bit ceilings. With these values a full 1024-entry load fits in a few thousand cycles. That full load brings within reach the pointer wrap from the last entry to the first, the top-of-curve neighbour rule in both halves, and a gamma lookup driven by a degamma result of 1023. The 8-bit legacy width also makes the bit-replication of legacy entries and the fixed fallback to entry 255 for overrange inputs directly observable.

// File: rtl/gp_pkg.sv
package gp_pkg;
  // host register word offsets (host_addr[3:0])
  localparam logic [3:0] OFS_PTR    = 4'h0;
  localparam logic [3:0] OFS_DATA   = 4'h1;
  localparam logic [3:0] OFS_CEIL_R = 4'h4;
  localparam logic [3:0] OFS_CEIL_G = 4'h5;
  localparam logic [3:0] OFS_CEIL_B = 4'h6;
  localparam logic [3:0] OFS_MODE   = 4'h8;

  localparam int STEP_BIT = 15;
  localparam int NUM_CH   = 3;
  localparam int PORTS_PER_CH = 4;

  typedef enum logic {
    MODE_LEGACY = 1'b0,
    MODE_SPLIT  = 1'b1
  } gp_mode_e;
endpackage

// File: rtl/gp_ram.sv
module gp_ram #(
  parameter int AW  = 10,
  parameter int DW  = 30,
  parameter int NRD = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [AW-1:0]           waddr,
  input  logic [DW-1:0]           wdata,
  input  logic [NRD-1:0]          rd_en,
  input  logic [NRD-1:0][AW-1:0]  rd_addr,
  output logic [NRD-1:0][DW-1:0]  rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rd_q [NRD];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // synchronous reads: a same-cycle write is not visible (old value)
  for (genvar p = 0; p < NRD; p++) begin : g_rd
    always_ff @(posedge clk) begin
      if (rd_en[p]) rd_q[p] <= mem[rd_addr[p]];
    end
    assign rd_data[p] = rd_q[p];
  end

  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/gp_host_regs.sv
module gp_host_regs
  import gp_pkg::*;
#(
  parameter int CH_W  = 10,
  parameter int LEG_W = 8,
  parameter int MAX_W = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          host_we,
  input  logic [LEG_W:0]                host_addr,
  input  logic [31:0]                   host_wdata,
  output logic                          mode_split,
  output logic [NUM_CH-1:0][MAX_W-1:0]  ceil_val,
  output logic                          pal_we,
  output logic [CH_W-1:0]               pal_waddr,
  output logic [3*CH_W-1:0]             pal_wdata,
  output logic                          leg_we,
  output logic [LEG_W-1:0]              leg_waddr,
  output logic [3*LEG_W-1:0]            leg_wdata
);
  logic              leg_sel;
  logic [3:0]        ofs;
  logic              ptr_wr, data_wr, mode_wr;
  logic [NUM_CH-1:0] ceil_wr;

  logic [CH_W-1:0]   ptr_q, ptr_d;
  logic              step_q, step_d;
  logic              ptr_en;
  gp_mode_e          mode_q, mode_d;

  logic wdata_unused, addr_unused;
  assign wdata_unused = ^host_wdata;
  assign addr_unused  = ^host_addr;

  // decode
  always_comb begin
    leg_sel = host_addr[LEG_W];
    ofs     = host_addr[3:0];
    ptr_wr  = host_we && !leg_sel && (ofs == OFS_PTR);
    data_wr = host_we && !leg_sel && (ofs == OFS_DATA);
    mode_wr = host_we && !leg_sel && (ofs == OFS_MODE);
    ceil_wr[0] = host_we && !leg_sel && (ofs == OFS_CEIL_R);
    ceil_wr[1] = host_we && !leg_sel && (ofs == OFS_CEIL_G);
    ceil_wr[2] = host_we && !leg_sel && (ofs == OFS_CEIL_B);
  end

  // pointer next state
  always_comb begin
    ptr_d  = ptr_q;
    step_d = step_q;
    ptr_en = 1'b0;
    if (ptr_wr) begin
      ptr_d  = host_wdata[CH_W-1:0];
      step_d = host_wdata[STEP_BIT];
      ptr_en = 1'b1;
    end else if (data_wr && step_q) begin
      ptr_d  = ptr_q + 1'b1;
      ptr_en = 1'b1;
    end
    mode_d = host_wdata[0] ? MODE_SPLIT : MODE_LEGACY;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      step_q <= 1'b0;
    end else if (ptr_en) begin
      ptr_q  <= ptr_d;
      step_q <= step_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= MODE_LEGACY;
    else if (mode_wr) mode_q <= mode_d;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ceil
    logic [MAX_W-1:0] ceil_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          ceil_q <= '1;
      else if (ceil_wr[c]) ceil_q <= host_wdata[MAX_W-1:0];
    end
    assign ceil_val[c] = ceil_q;
  end

  assign mode_split = (mode_q == MODE_SPLIT);
  assign pal_we     = data_wr;
  assign pal_waddr  = ptr_q;
  assign pal_wdata  = host_wdata[3*CH_W-1:0];
  assign leg_we     = host_we && leg_sel;
  assign leg_waddr  = host_addr[LEG_W-1:0];
  assign leg_wdata  = host_wdata[3*LEG_W-1:0];

  assert_step_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && step_q) |=> ptr_q == $past(ptr_q) + 1'b1);
  assert_ptr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !step_q) |=> $stable(ptr_q));
  assert_legacy_keeps_ptr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    leg_we |=> ($stable(ptr_q) && $stable(step_q)));
endmodule

// File: rtl/gp_chan.sv
module gp_chan #(
  parameter int CH_W   = 10,
  parameter int LEG_W  = 8,
  parameter int MAX_W  = 16,
  parameter int CH_IDX = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [CH_W:0]      in_pix,
  input  logic               v1,
  input  logic               v2,
  input  logic               split2,
  input  logic [MAX_W-1:0]   ceil_val,
  output logic [CH_W-1:0]    deg_raddr_lo,
  output logic [CH_W-1:0]    deg_raddr_hi,
  input  logic [3*CH_W-1:0]  deg_word_lo,
  input  logic [3*CH_W-1:0]  deg_word_hi,
  output logic [CH_W-1:0]    gam_raddr_lo,
  output logic [CH_W-1:0]    gam_raddr_hi,
  input  logic [3*CH_W-1:0]  gam_word_lo,
  input  logic [3*CH_W-1:0]  gam_word_hi,
  output logic [LEG_W-1:0]   leg_raddr,
  input  logic [3*LEG_W-1:0] leg_word,
  output logic [CH_W-1:0]    out_val
);
  localparam int HAW = CH_W - 1;
  localparam int FSH = (2 - CH_IDX) * CH_W;
  localparam int LSH = (2 - CH_IDX) * LEG_W;
  localparam int EXT = CH_W - LEG_W;
  localparam logic [HAW-1:0] TOP = '1;

  function automatic logic [CH_W-1:0] half_blend(input logic [CH_W-1:0] lo,
                                                 input logic [CH_W-1:0] hi,
                                                 input logic f);
    logic [CH_W:0] s;
    s = {1'b0, lo} + {1'b0, hi};
    return f ? s[CH_W:1] : lo;
  endfunction

  logic             frac1, ovr1, frac2, ovr2;
  logic [LEG_W-1:0] leg2;
  logic [CH_W-1:0]  out_q;
  logic [HAW-1:0]   deg_a, gam_a;
  logic [CH_W-1:0]  deg_val, gam_val, leg_ext, out_d;

  always_comb begin
    // stage 0: degamma and legacy addresses
    deg_a        = in_pix[CH_W-1:1];
    deg_raddr_lo = {1'b0, deg_a};
    deg_raddr_hi = {1'b0, (deg_a == TOP) ? deg_a : deg_a + 1'b1};
    leg_raddr    = in_pix[CH_W] ? {LEG_W{1'b1}} : in_pix[CH_W-1 -: LEG_W];
    // stage 1: degamma blend, gamma addresses
    deg_val      = half_blend(deg_word_lo[FSH +: CH_W], deg_word_hi[FSH +: CH_W], frac1);
    gam_a        = deg_val[CH_W-1:1];
    gam_raddr_lo = {1'b1, gam_a};
    gam_raddr_hi = {1'b1, (gam_a == TOP) ? gam_a : gam_a + 1'b1};
    // stage 2: gamma blend, output select
    gam_val      = half_blend(gam_word_lo[FSH +: CH_W], gam_word_hi[FSH +: CH_W], frac2);
    leg_ext      = {leg2, leg2[LEG_W-1 -: EXT]};
    if (!split2)   out_d = leg_ext;
    else if (ovr2) out_d = ceil_val[MAX_W-1 -: CH_W];
    else           out_d = gam_val;
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      frac1 <= in_pix[0];
      ovr1  <= in_pix[CH_W];
    end
  end

  always_ff @(posedge clk) begin
    if (v1) begin
      frac2 <= deg_val[0];
      ovr2  <= ovr1;
      leg2  <= leg_word[LSH +: LEG_W];
    end
  end

  always_ff @(posedge clk) begin
    if (v2) out_q <= out_d;
  end

  assign out_val = out_q;

  assert_overrange_ceiling_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (v2 && split2 && ovr2) |=> out_val == $past(ceil_val[MAX_W-1 -: CH_W]));
  assert_legacy_expand_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (v2 && !split2) |=> out_val[CH_W-1 -: LEG_W] == $past(leg2));
endmodule

// File: rtl/gamma_palette.sv
module gamma_palette
  import gp_pkg::*;
#(
  parameter int CH_W  = 10,
  parameter int LEG_W = 8,
  parameter int MAX_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            host_we,
  input  logic [LEG_W:0]  host_addr,
  input  logic [31:0]     host_wdata,
  input  logic            pix_valid,
  input  logic [CH_W:0]   pix_r,
  input  logic [CH_W:0]   pix_g,
  input  logic [CH_W:0]   pix_b,
  output logic            out_valid,
  output logic [CH_W-1:0] out_r,
  output logic [CH_W-1:0] out_g,
  output logic [CH_W-1:0] out_b
);
  localparam int PAL_DW = 3 * CH_W;
  localparam int LEG_DW = 3 * LEG_W;
  localparam int PAL_RD = NUM_CH * PORTS_PER_CH;

  logic                          mode_split;
  logic [NUM_CH-1:0][MAX_W-1:0]  ceil_val;
  logic                          pal_we, leg_we;
  logic [CH_W-1:0]               pal_waddr;
  logic [PAL_DW-1:0]             pal_wdata;
  logic [LEG_W-1:0]              leg_waddr;
  logic [LEG_DW-1:0]             leg_wdata;

  logic [PAL_RD-1:0]             pal_ren;
  logic [PAL_RD-1:0][CH_W-1:0]   pal_raddr;
  logic [PAL_RD-1:0][PAL_DW-1:0] pal_rdata;
  logic [NUM_CH-1:0][LEG_W-1:0]  leg_raddr;
  logic [NUM_CH-1:0][LEG_DW-1:0] leg_rdata;

  logic [CH_W:0]   pix_in  [NUM_CH];
  logic [CH_W-1:0] out_val [NUM_CH];

  logic v1_q, v2_q, v3_q, v1_d, v2_d, v3_d;
  logic split1_q, split2_q;

  gp_host_regs #(.CH_W(CH_W), .LEG_W(LEG_W), .MAX_W(MAX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .mode_split(mode_split), .ceil_val(ceil_val),
    .pal_we(pal_we), .pal_waddr(pal_waddr), .pal_wdata(pal_wdata),
    .leg_we(leg_we), .leg_waddr(leg_waddr), .leg_wdata(leg_wdata)
  );

  gp_ram #(.AW(CH_W), .DW(PAL_DW), .NRD(PAL_RD)) u_pal (
    .clk(clk), .rst_n(rst_n), .we(pal_we), .waddr(pal_waddr), .wdata(pal_wdata),
    .rd_en(pal_ren), .rd_addr(pal_raddr), .rd_data(pal_rdata)
  );

  gp_ram #(.AW(LEG_W), .DW(LEG_DW), .NRD(NUM_CH)) u_leg (
    .clk(clk), .rst_n(rst_n), .we(leg_we), .waddr(leg_waddr), .wdata(leg_wdata),
    .rd_en({NUM_CH{pix_valid}}), .rd_addr(leg_raddr), .rd_data(leg_rdata)
  );

  assign pix_in[0] = pix_r;
  assign pix_in[1] = pix_g;
  assign pix_in[2] = pix_b;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int B = c * PORTS_PER_CH;
    logic [CH_W-1:0]  dlo, dhi, glo, ghi;
    logic [LEG_W-1:0] la;

    gp_chan #(.CH_W(CH_W), .LEG_W(LEG_W), .MAX_W(MAX_W), .CH_IDX(c)) u_chan (
      .clk(clk), .rst_n(rst_n), .in_valid(pix_valid), .in_pix(pix_in[c]),
      .v1(v1_q), .v2(v2_q), .split2(split2_q), .ceil_val(ceil_val[c]),
      .deg_raddr_lo(dlo), .deg_raddr_hi(dhi),
      .deg_word_lo(pal_rdata[B]), .deg_word_hi(pal_rdata[B+1]),
      .gam_raddr_lo(glo), .gam_raddr_hi(ghi),
      .gam_word_lo(pal_rdata[B+2]), .gam_word_hi(pal_rdata[B+3]),
      .leg_raddr(la), .leg_word(leg_rdata[c]), .out_val(out_val[c])
    );

    assign pal_raddr[B]   = dlo;
    assign pal_raddr[B+1] = dhi;
    assign pal_raddr[B+2] = glo;
    assign pal_raddr[B+3] = ghi;
    assign pal_ren[B]     = pix_valid;
    assign pal_ren[B+1]   = pix_valid;
    assign pal_ren[B+2]   = v1_q;
    assign pal_ren[B+3]   = v1_q;
    assign leg_raddr[c]   = la;
  end

  // valid pipeline
  always_comb begin
    v1_d = pix_valid;
    v2_d = v1_q;
    v3_d = v2_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
      v3_q <= 1'b0;
    end else begin
      v1_q <= v1_d;
      v2_q <= v2_d;
      v3_q <= v3_d;
    end
  end

  // mode travels with the pixel
  always_ff @(posedge clk) begin
    if (pix_valid) split1_q <= mode_split;
  end

  always_ff @(posedge clk) begin
    if (v1_q) split2_q <= split1_q;
  end

  assign out_valid = v3_q;
  assign out_r     = out_val[0];
  assign out_g     = out_val[1];
  assign out_b     = out_val[2];

  assert_three_cycle_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> ##3 out_valid);
  assert_no_spurious_output_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!pix_valid) |-> ##3 !out_valid);
endmodule

// File: tb/sim_gamma_palette.sv
`timescale 1ns/1ps
module sim_gamma_palette;
  localparam int CH_W = 10, LEG_W = 8, MAX_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          host_we = 1'b0;
  logic [8:0]    host_addr = '0;
  logic [31:0]   host_wdata = '0;
  logic          pix_valid = 1'b0;
  logic [10:0]   pix_r = '0, pix_g = '0, pix_b = '0;
  logic          out_valid;
  logic [9:0]    out_r, out_g, out_b;

  gamma_palette #(.CH_W(CH_W), .LEG_W(LEG_W), .MAX_W(MAX_W)) u0 (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .pix_valid(pix_valid), .pix_r(pix_r),
    .pix_g(pix_g), .pix_b(pix_b), .out_valid(out_valid),
    .out_r(out_r), .out_g(out_g), .out_b(out_b)
  );

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  // shadow of the requirements-level state
  logic [29:0] pal [1024];
  logic [23:0] leg [256];
  logic [15:0] ceilv [3];
  bit          split_m = 0;
  int          bptr = 0;
  bit          bstep = 0;

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [9:0] fld(logic [29:0] w, int ch);
    return w[(2-ch)*10 +: 10];
  endfunction

  function automatic logic [9:0] mix(logic [9:0] lo, logic [9:0] hi, bit f);
    int s;
    s = int'(lo) + int'(hi);
    return f ? 10'(s / 2) : lo;
  endfunction

  function automatic logic [9:0] expect_ch(int ch, logic [10:0] v);
    int n, nn, j, jn;
    logic [9:0] d;
    logic [7:0] e;
    if (!split_m) begin
      n = v[10] ? 255 : int'(v[9:2]);
      e = leg[n][(2-ch)*8 +: 8];
      return {e, e[7:6]};
    end
    if (v[10]) return ceilv[ch][15:6];
    n  = int'(v[9:1]);
    nn = (n == 511) ? 511 : n + 1;
    d  = mix(fld(pal[n], ch), fld(pal[nn], ch), v[0]);
    j  = int'(d[9:1]);
    jn = (j == 511) ? 511 : j + 1;
    return mix(fld(pal[512+j], ch), fld(pal[512+jn], ch), d[0]);
  endfunction

  task automatic host_write(logic [8:0] a, logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic set_ptr(int p, bit step);
    host_write(9'h000, (step ? 32'h8000 : 32'h0) | 32'(p));
    bptr = p; bstep = step;
  endtask

  task automatic put_data(logic [29:0] w);
    host_write(9'h001, {2'b00, w});
    pal[bptr] = w;
    if (bstep) bptr = (bptr + 1) % 1024;
  endtask

  task automatic put_leg(int e, logic [23:0] w);
    host_write(9'h100 | 9'(e), {8'h00, w});
    leg[e] = w;
  endtask

  task automatic set_ceil(int ch, logic [15:0] v);
    host_write(9'(4 + ch), {16'h0, v});
    ceilv[ch] = v;
  endtask

  task automatic set_mode(bit s);
    host_write(9'h008, {31'h0, s});
    split_m = s;
  endtask

  task automatic pixel(logic [10:0] r, logic [10:0] g, logic [10:0] b, string tag);
    logic [29:0] exp;
    exp = {expect_ch(0, r), expect_ch(1, g), expect_ch(2, b)};
    @(negedge clk);
    pix_valid = 1'b1; pix_r = r; pix_g = g; pix_b = b;
    @(negedge clk);
    pix_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check({tag, " valid"}, {31'h0, out_valid}, 32'h1);
    check(tag, {2'b00, out_r, out_g, out_b}, {2'b00, exp});
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    check("R1 out_valid after reset", {31'h0, out_valid}, 32'h0);
    ceilv[0] = 16'hFFFF; ceilv[1] = 16'hFFFF; ceilv[2] = 16'hFFFF;
    set_mode(1);
    pixel(11'h400, 11'h400, 11'h7FF, "R1 default ceiling");
  endtask

  task automatic t_fill();
    set_ptr(0, 1);
    for (int i = 0; i < 512; i++)
      put_data({10'((i * 37) % 1024), 10'(1023 - 2 * i), 10'((i * i) % 1024)});
    for (int j = 0; j < 512; j++)
      put_data({10'((j * 5 + 3) % 1024), 10'(j * 2), 10'(1023 - j)});
    check("R3 pointer wrapped after full load", 32'(bptr), 32'd0);
    pixel(11'd0, 11'd0, 11'd0, "R4 zero input");
    pixel(11'd200, 11'd514, 11'd90, "R2 R4 even inputs");
    pixel(11'd1000, 11'd32, 11'd700, "R4 mixed even inputs");
  endtask

  task automatic t_odd();
    pixel(11'd1, 11'd333, 11'd777, "R5 odd inputs");
    pixel(11'd1023, 11'd1022, 11'd1023, "R5 top entry neighbour");
    pixel(11'd511, 11'd513, 11'd129, "R5 mid odd inputs");
  endtask

  task automatic t_ceiling();
    set_ceil(0, 16'h1234);
    set_ceil(2, 16'h0040);
    pixel(11'h400, 11'd40, 11'd41, "R6 red overrange only");
    pixel(11'd8, 11'h400, 11'h5FF, "R6 green and blue overrange");
  endtask

  task automatic t_wrap();
    set_ptr(1023, 1);
    put_data({10'd17, 10'd600, 10'd901});
    put_data({10'h3FF, 10'h3FF, 10'h3FF});
    check("R3 shadow wrap", 32'(bptr), 32'd1);
    pixel(11'd0, 11'd0, 11'd0, "R3 wrap 1023 to 0");
  endtask

  task automatic t_nostep();
    set_ptr(5, 0);
    put_data({10'd100, 10'd200, 10'd300});
    put_data({10'd11, 10'd22, 10'd33});
    pixel(11'd10, 11'd10, 11'd10, "R3 no step overwrite");
    pixel(11'd12, 11'd12, 11'd12, "R3 neighbour untouched");
  endtask

  task automatic t_legacy();
    set_ptr(300, 1);
    set_mode(0);
    put_leg(0, 24'hA1B2C3);
    put_leg(77, 24'h10C0FF);
    put_leg(255, 24'h4080C1);
    pixel(11'd0, 11'd1, 11'd3, "R7 legacy entry 0");
    pixel(11'd308, 11'd309, 11'd311, "R7 legacy entry 77");
    pixel(11'h400, 11'd1023, 11'h400, "R7 legacy overrange to 255");
    set_mode(1);
    put_data({10'd444, 10'd555, 10'd666});
    pixel(11'd600, 11'd600, 11'd600, "R8 pointer kept across legacy writes");
    put_data({10'd1, 10'd2, 10'd3});
    pixel(11'd602, 11'd602, 11'd602, "R8 step continued");
  endtask

  task automatic t_collide();
    logic [29:0] old_exp;
    set_ptr(100, 0);
    old_exp = {expect_ch(0, 11'd200), expect_ch(1, 11'd200), expect_ch(2, 11'd200)};
    @(negedge clk);
    host_we = 1'b1; host_addr = 9'h001; host_wdata = {2'b00, 10'd5, 10'd6, 10'd7};
    pix_valid = 1'b1; pix_r = 11'd200; pix_g = 11'd200; pix_b = 11'd200;
    @(negedge clk);
    host_we = 1'b0; pix_valid = 1'b0;
    pal[100] = {10'd5, 10'd6, 10'd7};
    @(negedge clk);
    @(negedge clk);
    check("R9 same-cycle read sees old", {2'b00, out_r, out_g, out_b}, {2'b00, old_exp});
    pixel(11'd200, 11'd200, 11'd200, "R9 next read sees new");
  endtask

  task automatic t_stream();
    logic [10:0] sr [6];
    logic [29:0] se [6];
    for (int i = 0; i < 6; i++) begin
      sr[i] = 11'((i * 173 + 9) % 1024);
      se[i] = {expect_ch(0, sr[i]), expect_ch(1, sr[i] ^ 11'h155), expect_ch(2, sr[i] ^ 11'h0AA)};
    end
    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      if (i >= 3) begin
        check("R10 stream valid", {31'h0, out_valid}, 32'h1);
        check("R10 stream order", {2'b00, out_r, out_g, out_b}, {2'b00, se[i-3]});
      end
      if (i < 6) begin
        pix_valid = 1'b1; pix_r = sr[i]; pix_g = sr[i] ^ 11'h155; pix_b = sr[i] ^ 11'h0AA;
      end else begin
        pix_valid = 1'b0;
      end
    end
    @(negedge clk);
    check("R10 stream drained", {31'h0, out_valid}, 32'h0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill();
    t_odd();
    t_ceiling();
    t_wrap();
    t_nostep();
    t_legacy();
    t_collide();
    t_stream();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule